// File: doc/BRIEF.md
# Split-Bank Write Strobe Decoder

This block sits between a processor bus with a 24-bit address and a 16-bit-wide memory region made of two byte-wide banks. The low bank holds the even byte addresses and the high bank holds the odd ones. One address comparison selects the whole 16-bit-wide region. The block then derives a separate active-low write strobe for each bank from address bit 0 and the active-low bus-high-enable. This lets the processor write the low byte, the high byte or a full word, and only the intended lanes are touched.

Reads are not split. A single gated read strobe goes to both banks, and the processor takes whichever byte or bytes it needs from the data bus. All outputs are pure combinational functions of the inputs, so each strobe follows the processor strobe with no added latency. A flag reports an access in the region that names no byte at all.

Top module: `bank_wr_strobe`

## Requirements
- R1: `region_cs_n_o` is low exactly when `mem_io_i` is 1 and address bits 23..12 equal 12'h006, i.e. the byte range 006000h–006FFFh.
- R2: When `mem_io_i` is 0 (an I/O cycle), the region select, both write strobes and the read strobe all stay high, whatever the address.
- R3: `lo_wr_n_o` is low exactly when the region is selected, `wr_n_i` is low and address bit 0 is 0.
- R4: `hi_wr_n_o` is low exactly when the region is selected, `wr_n_i` is low and `bhe_n_i` is 0.
- R5: A word write (address bit 0 = 0 with `bhe_n_i` = 0) drives both write strobes low in the same cycle.
- R6: A write to an address outside the region drives neither write strobe low.
- R7: `mem_rd_n_o` is low exactly when the region is selected and `rd_n_i` is low, whatever the byte lanes. While `wr_n_i` is high, no write strobe is low.
- R8: `no_lane_err_o` is 1 exactly when the region is selected, either `rd_n_i` or `wr_n_i` is low, address bit 0 is 1 and `bhe_n_i` is 1. In that case neither write strobe is low.
- R9: Each strobe output changes in the same clock cycle as the input strobe that causes it, with no register on the way.
- R10: A byte write through one lane leaves the byte stored in the other lane at the same word address unchanged. A word write stores data bits 7..0 in the low bank and bits 15..8 in the high bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 24 | Byte address; bit 0 picks the low lane when 0 |
| bhe_n_i | input | 1 | Active-low enable of the high byte lane |
| mem_io_i | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| rd_n_i | input | 1 | Active-low processor read strobe |
| wr_n_i | input | 1 | Active-low processor write strobe |
| region_cs_n_o | output | 1 | Active-low select of the 16-bit-wide region |
| mem_rd_n_o | output | 1 | Active-low read strobe shared by both banks |
| lo_wr_n_o | output | 1 | Active-low write strobe of the even bank |
| hi_wr_n_o | output | 1 | Active-low write strobe of the odd bank |
| no_lane_err_o | output | 1 | Access in the region with no byte lane enabled |

## Verification
The embedded assertions check the invariants that hold in every state of the block. No strobe is low in an I/O cycle, outside the region, or while the processor write strobe is high. A word write always opens both lanes, and an access that names no lane never produces a write strobe. Only the bench scenarios show the exact address window of the decoder at its edges, the lane chosen by each byte pattern, and the contents of two modelled byte-wide banks. Those contents show that a byte write keeps the neighbouring byte intact and that word data lands in the correct lanes.

// File: rtl/bank_wr_strobe_pkg.sv
package bank_wr_strobe_pkg;
   localparam int unsigned NUM_LANES = 2;
   localparam int unsigned LANE_LO   = 0;
   localparam int unsigned LANE_HI   = 1;

   typedef logic [NUM_LANES-1:0] lane_vec_t;

   // Lane enable pattern from address bit 0 and active-low high enable.
   function automatic lane_vec_t lanes_from_bus(input logic a0, input logic bhe_n);
      lane_vec_t v;
      v[LANE_LO] = ~a0;
      v[LANE_HI] = ~bhe_n;
      return v;
   endfunction
endpackage

// File: rtl/bsw_region_decode.sv
module bsw_region_decode #(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned REGION_LOG2 = 12,
   parameter logic [ADDR_W-1:0] REGION_BASE = 24'h006000
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              mem_io_i,
   output logic              hit_o
);
   localparam int unsigned TAG_W = ADDR_W - REGION_LOG2;

   generate
      if (REGION_LOG2 >= ADDR_W) begin : g_bad_size
         $error("region size must be smaller than the address space");
      end
      if (REGION_LOG2 < 1) begin : g_bad_min
         $error("region must span at least one 16-bit word");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] BASE_SHIFT = REGION_BASE >> REGION_LOG2;
   localparam logic [TAG_W-1:0]  TAG        = BASE_SHIFT[TAG_W-1:0];

   generate
      if ((BASE_SHIFT << REGION_LOG2) != REGION_BASE) begin : g_bad_align
         $error("region base must be aligned to the region size");
      end
   endgenerate

   logic tag_match;
   assign tag_match = (addr_i[ADDR_W-1:REGION_LOG2] == TAG);
   assign hit_o     = mem_io_i & tag_match;

   always_comb begin
      if (!mem_io_i) begin
         AST_IO_NO_HIT: assert (!hit_o) else $error("hit in io cycle"); // R2
      end
   end
endmodule

// File: rtl/bsw_lane_strobe.sv
module bsw_lane_strobe
   import bank_wr_strobe_pkg::*;
(
   input  logic       hit_i,
   input  logic       wr_n_i,
   input  logic       rd_n_i,
   input  logic       a0_i,
   input  logic       bhe_n_i,
   output lane_vec_t  wr_n_o,
   output logic       rd_n_o,
   output logic       no_lane_o
);
   lane_vec_t lanes;
   logic      access;

   assign lanes  = lanes_from_bus(a0_i, bhe_n_i);
   assign access = hit_i & (~wr_n_i | ~rd_n_i);

   genvar g;
   generate
      for (g = 0; g < NUM_LANES; g++) begin : g_lane
         assign wr_n_o[g] = ~(hit_i & ~wr_n_i & lanes[g]);
      end
   endgenerate

   assign rd_n_o    = ~(hit_i & ~rd_n_i);
   assign no_lane_o = access & (lanes == '0);

   always_comb begin
      if (wr_n_i) begin
         AST_NO_WR_WITHOUT_WR: assert (&wr_n_o) else $error("write strobe without write"); // R7
      end
      if (no_lane_o) begin
         AST_ERR_NO_STROBE: assert (&wr_n_o) else $error("strobe on empty lane set"); // R8
      end
   end
endmodule

// File: rtl/bank_wr_strobe.sv
module bank_wr_strobe
   import bank_wr_strobe_pkg::*;
#(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned REGION_LOG2 = 12,
   parameter logic [ADDR_W-1:0] REGION_BASE = 24'h006000
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              bhe_n_i,
   input  logic              mem_io_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   output logic              region_cs_n_o,
   output logic              mem_rd_n_o,
   output logic              lo_wr_n_o,
   output logic              hi_wr_n_o,
   output logic              no_lane_err_o
);
   generate
      if (NUM_LANES != 2) begin : g_bad_lanes
         $error("strobe generator is built for two byte lanes");
      end
   endgenerate

   logic      hit;
   lane_vec_t wr_n_vec;

   bsw_region_decode #(
      .ADDR_W      (ADDR_W),
      .REGION_LOG2 (REGION_LOG2),
      .REGION_BASE (REGION_BASE)
   ) u_decode (
      .addr_i   (addr_i),
      .mem_io_i (mem_io_i),
      .hit_o    (hit)
   );

   bsw_lane_strobe u_lanes (
      .hit_i     (hit),
      .wr_n_i    (wr_n_i),
      .rd_n_i    (rd_n_i),
      .a0_i      (addr_i[0]),
      .bhe_n_i   (bhe_n_i),
      .wr_n_o    (wr_n_vec),
      .rd_n_o    (mem_rd_n_o),
      .no_lane_o (no_lane_err_o)
   );

   assign region_cs_n_o = ~hit;
   assign lo_wr_n_o     = wr_n_vec[LANE_LO];
   assign hi_wr_n_o     = wr_n_vec[LANE_HI];

   always_comb begin
      if (region_cs_n_o) begin
         AST_OUTSIDE_NO_STROBE: assert (lo_wr_n_o && hi_wr_n_o && mem_rd_n_o)
            else $error("strobe outside region"); // R6
      end
      if (!mem_io_i) begin
         AST_IO_QUIET: assert (lo_wr_n_o && hi_wr_n_o && mem_rd_n_o)
            else $error("strobe in io cycle"); // R2
      end
      if (!region_cs_n_o && !wr_n_i && !addr_i[0] && !bhe_n_i) begin
         AST_WORD_BOTH_LANES: assert (!lo_wr_n_o && !hi_wr_n_o)
            else $error("word write missed a lane"); // R5
      end
      if (!lo_wr_n_o) begin
         AST_LO_NEEDS_EVEN: assert (!addr_i[0] && !wr_n_i)
            else $error("low strobe on odd address"); // R3
      end
      if (!hi_wr_n_o) begin
         AST_HI_NEEDS_BHE: assert (!bhe_n_i && !wr_n_i)
            else $error("high strobe without high enable"); // R4
      end
   end
endmodule

// File: tb/bank_wr_strobe_tb_top.sv
module bank_wr_strobe_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] addr;
   logic        bhe_n, mem_io, rd_n, wr_n;
   logic [15:0] wdata;
   logic        cs_n, rd_n_o, lo_n, hi_n, err;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   bank_wr_strobe dut_i (
      .addr_i        (addr),
      .bhe_n_i       (bhe_n),
      .mem_io_i      (mem_io),
      .rd_n_i        (rd_n),
      .wr_n_i        (wr_n),
      .region_cs_n_o (cs_n),
      .mem_rd_n_o    (rd_n_o),
      .lo_wr_n_o     (lo_n),
      .hi_wr_n_o     (hi_n),
      .no_lane_err_o (err)
   );

   typedef struct {
      logic [4:0] exp;   // {cs_n, rd_n, lo_n, hi_n, err}
      string      req;
   } item_t;
   item_t q[$];

   logic [7:0] bank_lo [2048];
   logic [7:0] bank_hi [2048];

   function automatic logic [4:0] model(input logic [23:0] a, input logic b_n,
                                        input logic m, input logic r_n, input logic w_n);
      logic sel;
      sel = m && (a[23:12] == 12'h006);
      return {!sel, !(sel && !r_n), !(sel && !w_n && !a[0]),
              !(sel && !w_n && !b_n), sel && (!r_n || !w_n) && a[0] && b_n};
   endfunction

   task automatic drive(input logic [23:0] a, input logic b_n, input logic m,
                        input logic r_n, input logic w_n, input logic [15:0] d,
                        input string req);
      item_t it;
      @(posedge clk);
      addr = a; bhe_n = b_n; mem_io = m; rd_n = r_n; wr_n = w_n; wdata = d;
      it.exp = model(a, b_n, m, r_n, w_n);
      it.req = req;
      q.push_back(it);
   endtask

   task automatic idle();
      drive(24'h000000, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R2");
   endtask

   task automatic check_byte(input logic [23:0] a, input logic [7:0] exp_lo,
                             input logic [7:0] exp_hi);
      n_vec++;
      if (bank_lo[a[11:1]] !== exp_lo || bank_hi[a[11:1]] !== exp_hi) begin
         n_bad++;
         $display("FAIL R10 addr=%h actual lo=%h hi=%h expected lo=%h hi=%h",
                  a, bank_lo[a[11:1]], bank_hi[a[11:1]], exp_lo, exp_hi);
      end
   endtask

   // Monitor: compare in the middle of each cycle, then update bank model.
   always @(negedge clk) begin
      if (rst_n && q.size() != 0) begin
         item_t it;
         logic [4:0] act;
         it  = q.pop_front();
         act = {cs_n, rd_n_o, lo_n, hi_n, err};
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%b expected=%b (cs,rd,lo,hi,err)",
                     it.req, addr, act, it.exp);
         end
         if (!lo_n) bank_lo[addr[11:1]] = wdata[7:0];
         if (!hi_n) bank_hi[addr[11:1]] = wdata[15:8];
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #4000000;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      finish_run();
   end

   initial begin
      addr = '0; bhe_n = 1'b1; mem_io = 1'b0; rd_n = 1'b1; wr_n = 1'b1; wdata = '0;
      for (int i = 0; i < 2048; i++) begin bank_lo[i] = 8'h00; bank_hi[i] = 8'h00; end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      idle();                                                        // idle state
      drive(24'h006000, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0, "R1");         // select, no strobe
      drive(24'h006FFF, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0, "R1");         // top edge
      drive(24'h005FFF, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0, "R1");         // below
      drive(24'h007000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, "R6");         // above, write
      drive(24'h106010, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, "R6");         // alias in high bits
      drive(24'h006010, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, "R2");         // io write
      drive(24'h006010, 1'b0, 1'b1, 1'b1, 1'b0, 16'hAABB, "R5");      // word write
      drive(24'h006011, 1'b0, 1'b1, 1'b1, 1'b0, 16'hCC00, "R4");      // high byte
      drive(24'h006010, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0011, "R3");      // low byte
      drive(24'h006021, 1'b1, 1'b1, 1'b1, 1'b0, 16'hEEEE, "R8");      // no lane write
      drive(24'h006021, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0, "R8");         // no lane read
      drive(24'h006020, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0, "R7");         // read low
      drive(24'h006021, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0, "R7");         // read high
      drive(24'h006020, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0, "R7");         // read word
      // R9: strobe toggles on consecutive cycles, each compared same cycle
      for (int k = 0; k < 4; k++) begin
         drive(24'h006040, 1'b0, 1'b1, 1'b1, k[0], 16'h1234, "R9");
      end
      for (int k = 0; k < 8; k++) begin
         logic [23:0] a;
         a = 24'h006100 + 24'(k);
         drive(a, k[1], 1'b1, 1'b1, 1'b0, 16'h5A00 | 16'(k), "R3");
      end
      idle();
      @(posedge clk);
      @(posedge clk);
      check_byte(24'h006010, 8'h11, 8'hCC);   // R10 both bytes kept
      check_byte(24'h006020, 8'h00, 8'h00);   // R10 empty-lane write stored nothing
      check_byte(24'h006040, 8'h34, 8'h12);   // R10 word lanes
      check_byte(24'h005FFE, 8'h00, 8'h00);   // R10 outside write (index aliases none)
      finish_run();
   end
endmodule